// File: doc/BRIEF.md
# DAC Zero-Run Mute Controller

This block watches the sample streams of four DACs and counts, for each one, how many midrail (all-zero) words have arrived in an unbroken run. A channel that has seen more than 1024 such words in a row is flagged as silent. One shared bidirectional pin connects the block to the board. In output direction the block drives the pin with the silent flag of one selected DAC. In input direction an external agent drives the pin, and a high level on it asks for soft mute. A soft-mute request vector, one bit per DAC, goes to the ramp logic that follows. The ramp itself is outside this block.

A two-bit channel selector picks which DAC the pin refers to. A decode-bypass bit removes that selection: with bypass set, a high pin level requests soft mute on every DAC at once. The same routing applies in both directions. In output direction the level acted upon is the value being driven. In input direction it is the pin value after a two-stage synchronizer.

Each DAC sample port is a valid/ready stream. A word is taken on a rising clock edge when both valid and ready are high. Ready is low while reset is held and from the first edge after reset it stays high, so the block never applies back-pressure. Words offered while ready is low are discarded. Pin drive, pin enable and the soft-mute vector are registered.

Top module: `zdm_mute_ctrl`

## Requirements
- R1: While reset is asserted, pin_drive, pin_oe, mute_req and samp_ready are all low, and every run count is zero.
- R2: A DAC's silent flag rises only when the 1025th consecutive zero word for that DAC is taken. After exactly 1024 zero words the flag is still low. Pin drive and mute_req reflect the change one clock edge after the taking edge.
- R3: Any accepted non-zero word, the most negative value included, clears that DAC's run count. The flag and the outputs derived from it drop one edge later, and a full fresh run of 1025 zero words is then needed to raise the flag again.
- R4: Cycles with valid low neither advance nor clear a run count.
- R5: The run count saturates. Runs far longer than 2048 words keep the flag high without wrapping.
- R6: With dir_out = 1, pin_oe is high and pin_drive equals the silent flag of DAC number sel (sel = 0 is DAC1, sel = 3 is DAC4). pin_in has no effect in this direction.
- R7: With decode_dis = 0, mute_req has at most bit sel set, and that bit equals the pin level (the driven flag in output direction, the synchronized pin_in in input direction).
- R8: With dir_out = 0, pin_oe and pin_drive are low. A change of pin_in reaches mute_req after the third rising edge: two synchronizer stages, then the output register.
- R9: With decode_dis = 1, all mute_req bits equal the pin level, whatever sel is, in either direction.
- R10: The four run counts are independent. Words on one DAC never change another DAC's count or flag.
- R11: Changes of sel, dir_out and decode_dis appear at the outputs after the next rising edge.
- R12: samp_ready is high for every DAC from the first rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_valid | input | 4 | Per-DAC word valid |
| samp_data | input | 96 | Per-DAC 24-bit word; DAC k in bits [24k+23:24k] |
| samp_ready | output | 4 | Per-DAC ready |
| dir_out | input | 1 | 1: block drives the pin; 0: pin is an input |
| sel | input | 2 | DAC chosen for the pin |
| decode_dis | input | 1 | 1: pin level applies to all DACs |
| pin_in | input | 1 | Level read from the pin pad |
| pin_drive | output | 1 | Level driven onto the pin |
| pin_oe | output | 1 | Pin output enable |
| mute_req | output | 4 | Per-DAC soft-mute request |

## Verification
A run count that is off by one appears as a pin that rises on the 1024th zero word or not until the 1026th. So the bench counts words exactly and checks the flag on both sides of the threshold, one edge after the taking edge. A count that wraps instead of saturating drops the flag after 2048 words, which a 2100-word run exposes. A count that is not cleared by a non-zero word shows up as an early flag on the following run. Routing faults are visible on the same edge through mute_req: a wrong bit, a missing broadcast, or a stray response to pin_in in output direction. Synchronizer depth errors show as a mute request one edge early or late.

// File: rtl/zdm_pkg.sv
package zdm_pkg;
  localparam int unsigned N_DAC_DEF     = 4;
  localparam int unsigned SAMPLE_W_DEF  = 24;
  localparam int unsigned RUN_LIMIT_DEF = 1024;
  localparam int unsigned SYNC_DEF      = 2;
endpackage

// File: rtl/zdm_run_counter.sv
module zdm_run_counter #(
  parameter int unsigned SAMPLE_W  = 24,
  parameter int unsigned RUN_LIMIT = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [SAMPLE_W-1:0] word,
  output logic                run_hit
);
  localparam int unsigned CNT_W = $clog2(RUN_LIMIT + 2);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(RUN_LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             is_mid;

  assign is_mid = (word == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (take) begin
      if (!is_mid) begin
        cnt_q <= '0;
      end else if (cnt_q != SAT) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign run_hit = (cnt_q == SAT);
endmodule

// File: rtl/zdm_pin_sync.sv
module zdm_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] st_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q[g] <= 1'b0;
        end else begin
          if (g == 0) begin
            st_q[g] <= din;
          end else begin
            st_q[g] <= st_q[(g == 0) ? 0 : g - 1];
          end
        end
      end
    end
  endgenerate

  assign dout = st_q[STAGES-1];
endmodule

// File: rtl/zdm_mute_route.sv
module zdm_mute_route #(
  parameter int unsigned N_DAC = 4,
  localparam int unsigned SEL_W = (N_DAC > 1) ? $clog2(N_DAC) : 1
) (
  input  logic             dir_out,
  input  logic [SEL_W-1:0] sel,
  input  logic             decode_dis,
  input  logic [N_DAC-1:0] run_hit,
  input  logic             pin_sync,
  output logic             drive_d,
  output logic             oe_d,
  output logic [N_DAC-1:0] mute_d
);
  logic             chosen_flag;
  logic             level;
  logic [N_DAC-1:0] pick;

  assign chosen_flag = run_hit[sel];
  assign level       = dir_out ? chosen_flag : pin_sync;
  assign drive_d     = dir_out & chosen_flag;
  assign oe_d        = dir_out;

  always_comb begin
    pick = '0;
    pick[sel] = 1'b1;
  end

  assign mute_d = decode_dis ? {N_DAC{level}} : (pick & {N_DAC{level}});
endmodule

// File: rtl/zdm_mute_ctrl.sv
module zdm_mute_ctrl
  import zdm_pkg::*;
#(
  parameter int unsigned N_DAC     = N_DAC_DEF,
  parameter int unsigned SAMPLE_W  = SAMPLE_W_DEF,
  parameter int unsigned RUN_LIMIT = RUN_LIMIT_DEF,
  parameter int unsigned SYNC_N    = SYNC_DEF,
  localparam int unsigned SEL_W    = (N_DAC > 1) ? $clog2(N_DAC) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_DAC-1:0]          samp_valid,
  input  logic [N_DAC*SAMPLE_W-1:0] samp_data,
  output logic [N_DAC-1:0]          samp_ready,
  input  logic                      dir_out,
  input  logic [SEL_W-1:0]          sel,
  input  logic                      decode_dis,
  input  logic                      pin_in,
  output logic                      pin_drive,
  output logic                      pin_oe,
  output logic [N_DAC-1:0]          mute_req
);
  logic             rdy_q;
  logic [N_DAC-1:0] run_hit;
  logic             pin_sync;
  logic             drive_d;
  logic             oe_d;
  logic [N_DAC-1:0] mute_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign samp_ready = {N_DAC{rdy_q}};

  genvar d;
  generate
    for (d = 0; d < N_DAC; d++) begin : g_dac
      zdm_run_counter #(
        .SAMPLE_W (SAMPLE_W),
        .RUN_LIMIT(RUN_LIMIT)
      ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (samp_valid[d] & rdy_q),
        .word   (samp_data[d*SAMPLE_W +: SAMPLE_W]),
        .run_hit(run_hit[d])
      );
    end
  endgenerate

  zdm_pin_sync #(.STAGES(SYNC_N)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .dout (pin_sync)
  );

  zdm_mute_route #(.N_DAC(N_DAC)) u_route (
    .dir_out   (dir_out),
    .sel       (sel),
    .decode_dis(decode_dis),
    .run_hit   (run_hit),
    .pin_sync  (pin_sync),
    .drive_d   (drive_d),
    .oe_d      (oe_d),
    .mute_d    (mute_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_drive <= 1'b0;
      pin_oe    <= 1'b0;
      mute_req  <= '0;
    end else begin
      pin_drive <= drive_d;
      pin_oe    <= oe_d;
      mute_req  <= mute_d;
    end
  end
endmodule

// File: rtl/zdm_mute_ctrl_chk.sv
module zdm_mute_ctrl_chk #(
  parameter int unsigned N_DAC    = 4,
  parameter int unsigned SAMPLE_W = 24
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [N_DAC-1:0]          samp_valid,
  input logic [N_DAC*SAMPLE_W-1:0] samp_data,
  input logic [N_DAC-1:0]          samp_ready,
  input logic                      dir_out,
  input logic                      decode_dis,
  input logic                      pin_drive,
  input logic                      pin_oe,
  input logic [N_DAC-1:0]          mute_req,
  input logic [N_DAC-1:0]          run_hit
);
  logic [N_DAC-1:0] acc_zero;
  logic [N_DAC-1:0] acc_nz;

  always_comb begin
    for (int i = 0; i < N_DAC; i++) begin
      acc_zero[i] = samp_valid[i] & samp_ready[i] & (samp_data[i*SAMPLE_W +: SAMPLE_W] == '0);
      acc_nz[i]   = samp_valid[i] & samp_ready[i] & (samp_data[i*SAMPLE_W +: SAMPLE_W] != '0);
    end
  end

  p_oe_follows_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pin_oe == $past(dir_out)));

  p_input_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_drive);

  p_single_mute_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !decode_dis |=> $onehot0(mute_req));

  p_broadcast_r9: assert property (@(posedge clk) disable iff (!rst_n)
    decode_dis |=> (mute_req == '0 || mute_req == {N_DAC{1'b1}}));

  genvar k;
  generate
    for (k = 0; k < N_DAC; k++) begin : g_chk
      p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_nz[k] |=> !run_hit[k]);
      p_hold_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_hit[k] && acc_zero[k]) |=> run_hit[k]);
      p_rise_on_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_hit[k]) |-> $past(acc_zero[k]));
    end
  endgenerate
endmodule

bind zdm_mute_ctrl zdm_mute_ctrl_chk #(
  .N_DAC   (N_DAC),
  .SAMPLE_W(SAMPLE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .samp_valid(samp_valid),
  .samp_data (samp_data),
  .samp_ready(samp_ready),
  .dir_out   (dir_out),
  .decode_dis(decode_dis),
  .pin_drive (pin_drive),
  .pin_oe    (pin_oe),
  .mute_req  (mute_req),
  .run_hit   (run_hit)
);

// File: tb/zdm_mute_ctrl_bench.sv
module zdm_mute_ctrl_bench;
  localparam int N = 4;
  localparam int W = 24;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   samp_valid = '0;
  logic [N*W-1:0] samp_data = '0;
  logic [N-1:0]   samp_ready;
  logic           dir_out = 1'b1;
  logic [1:0]     sel = 2'd0;
  logic           decode_dis = 1'b0;
  logic           pin_in = 1'b0;
  logic           pin_drive;
  logic           pin_oe;
  logic [N-1:0]   mute_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    string      req;
    logic [3:0] mute;
    logic       drv;
    logic       oe;
    logic [3:0] rdy;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  zdm_mute_ctrl u_zdm_mute_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp_valid(samp_valid),
    .samp_data (samp_data),
    .samp_ready(samp_ready),
    .dir_out   (dir_out),
    .sel       (sel),
    .decode_dis(decode_dis),
    .pin_in    (pin_in),
    .pin_drive (pin_drive),
    .pin_oe    (pin_oe),
    .mute_req  (mute_req)
  );

  task automatic expect_out(string req, logic [3:0] m, logic drv, logic oe, logic [3:0] rdy);
    exp_t e;
    e.req = req; e.mute = m; e.drv = drv; e.oe = oe; e.rdy = rdy;
    exp_q.push_back(e);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic feed(int d, logic [W-1:0] v, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      samp_valid    = '0;
      samp_valid[d] = 1'b1;
      samp_data[d*W +: W] = v;
    end
    @(negedge clk);
    samp_valid = '0;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        total++;
        if (mute_req !== e.mute || pin_drive !== e.drv || pin_oe !== e.oe || samp_ready !== e.rdy) begin
          bad++;
          $display("FAIL %s: mute=%b drv=%b oe=%b rdy=%b expected mute=%b drv=%b oe=%b rdy=%b",
                   e.req, mute_req, pin_drive, pin_oe, samp_ready, e.mute, e.drv, e.oe, e.rdy);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    // R1: reset state, with a zero word offered during reset
    samp_valid[0] = 1'b1;
    step(3);
    expect_out("R1 reset", 4'b0000, 1'b0, 1'b0, 4'b0000);
    samp_valid = '0;
    step(1);
    rst_n = 1'b1;
    step(2);
    // R12 ready, R6 output direction enable
    expect_out("R12 ready after reset", 4'b0000, 1'b0, 1'b1, 4'b1111);

    // R2 threshold on DAC1
    feed(0, '0, 1024);
    step(1);
    expect_out("R2 1024 zeros not enough", 4'b0000, 1'b0, 1'b1, 4'b1111);
    feed(0, '0, 1);
    step(1);
    expect_out("R2 R7 1025th zero flags DAC1", 4'b0001, 1'b1, 1'b1, 4'b1111);
    step(5);
    expect_out("R4 idle keeps flag", 4'b0001, 1'b1, 1'b1, 4'b1111);

    // R3 clear, R4 idle gaps do not advance the run
    feed(0, 24'h000005, 1);
    step(1);
    expect_out("R3 nonzero clears", 4'b0000, 1'b0, 1'b1, 4'b1111);
    feed(0, '0, 600);
    step(10);
    feed(0, '0, 424);
    step(1);
    expect_out("R4 R3 fresh run of 1024 with gap", 4'b0000, 1'b0, 1'b1, 4'b1111);
    feed(0, '0, 1);
    step(1);
    expect_out("R3 fresh 1025th flags", 4'b0001, 1'b1, 1'b1, 4'b1111);

    // R11 select change, R10 independence
    sel = 2'd1;
    step(1);
    expect_out("R11 R10 sel DAC2 idle", 4'b0000, 1'b0, 1'b1, 4'b1111);

    // R5 saturation on DAC2
    feed(1, '0, 2100);
    step(1);
    expect_out("R5 long run stays flagged", 4'b0010, 1'b1, 1'b1, 4'b1111);
    feed(1, 24'h800000, 1);
    step(1);
    expect_out("R3 most negative clears", 4'b0000, 1'b0, 1'b1, 4'b1111);
    sel = 2'd0;
    step(1);
    expect_out("R10 DAC1 untouched", 4'b0001, 1'b1, 1'b1, 4'b1111);

    // R9 broadcast in output direction
    decode_dis = 1'b1;
    step(1);
    expect_out("R9 output broadcast", 4'b1111, 1'b1, 1'b1, 4'b1111);
    sel = 2'd1;
    step(1);
    expect_out("R9 broadcast of low level", 4'b0000, 1'b0, 1'b1, 4'b1111);

    // R8 input direction with synchronizer latency
    decode_dis = 1'b0;
    dir_out = 1'b0;
    sel = 2'd2;
    step(1);
    expect_out("R8 input direction quiet", 4'b0000, 1'b0, 1'b0, 4'b1111);
    pin_in = 1'b1;
    step(2);
    expect_out("R8 two edges not yet", 4'b0000, 1'b0, 1'b0, 4'b1111);
    step(1);
    expect_out("R8 R7 third edge mutes DAC3", 4'b0100, 1'b0, 1'b0, 4'b1111);
    decode_dis = 1'b1;
    step(1);
    expect_out("R9 input broadcast", 4'b1111, 1'b0, 1'b0, 4'b1111);
    pin_in = 1'b0;
    step(3);
    expect_out("R9 input release", 4'b0000, 1'b0, 1'b0, 4'b1111);

    // R6 pin_in ignored in output direction
    decode_dis = 1'b0;
    dir_out = 1'b1;
    pin_in = 1'b1;
    step(4);
    expect_out("R6 pin_in ignored", 4'b0000, 1'b0, 1'b1, 4'b1111);
    pin_in = 1'b0;

    // R6 R7 DAC4 selection
    sel = 2'd3;
    feed(3, '0, 1025);
    step(1);
    expect_out("R6 R7 DAC4 flagged", 4'b1000, 1'b1, 1'b1, 4'b1111);

    step(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule